// File: doc/BRIEF.md
# Direct-Mapped Cache with Banked Refill

This block is a read/write cache placed between a processor word port and a main-memory timing model made of four interleaved banks. Each 32-bit byte address is split into a tag, a line index and a byte offset. Every line keeps a valid flag, a tag and a four-word data block. A read that finds a valid line with a matching tag is answered in the same cycle. A read that misses holds the processor off while the whole block is brought in from the banks, and the read then completes from the freshly filled line.

Writes go straight through to memory and never allocate a line. A write that hits also updates the cached word. Every write holds the processor until the memory has taken the word. The memory model is part of the block, so the exact stall lengths can be observed at the processor port. It counts one bus cycle to send the address, then fifteen cycles of bank access, overlapped across all four banks, then one bus cycle for each word transferred.

The processor raises `cpuReq` with `cpuWe`, `cpuAddr` and `cpuWdata` and holds them stable until it sees `cpuReady` high. Read data is valid in the cycle `cpuReady` is high.

Top module: `dmCache`

## Requirements
- R1: Address bits [31:12] are the tag, bits [11:4] the line index (256 lines), bits [3:2] the word within the block, and bits [1:0] are ignored, so 0x1006 reads the same word as 0x1004.
- R2: Reset clears every valid flag, so the first read of any line after reset misses and stalls for the full refill.
- R3: A read whose index selects a valid line with an equal tag raises `cpuReady` in the same cycle the request is presented, with that word on `cpuRdata`.
- R4: A read miss presented in cycle t keeps `cpuReady` low through cycle t+20, because the refill takes 20 bus cycles (1 address send, 15 bank access, 4 word transfers). It raises `cpuReady` in cycle t+21 with the word memory holds.
- R5: A refill loads all four words of the block, one from each bank, with the word bits [3:2] selecting the bank. Reads of the other words of that block then hit.
- R6: A read miss to an index whose line holds a different tag replaces that line, so the previous block misses again on its next read.
- R7: Every write holds `cpuReady` low through cycle t+15 and raises it in cycle t+16, when memory takes the word. A write never allocates a line or changes a valid flag, so a read after a write miss to the same block still misses.
- R8: A write that hits also updates the cached word, so a following read hits and returns the new value.
- R9: `cpuReady` is high only while `cpuReq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuReq | input | 1 | Access request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 32 | Byte address |
| cpuWdata | input | 32 | Write data |
| cpuReady | output | 1 | Access completes in this cycle |
| cpuRdata | output | 32 | Read data, valid while `cpuReady` is high on a read |

## Verification
The bench counts the exact number of stalled cycles for each access. A refill that is one cycle short or long, or that treats memory as a fixed-latency store, would give the wrong latency. It forces conflicts, meaning two blocks with equal index and different tags. A design that compared only the index would wrongly return the stale block as a hit. It reads the neighbours of a just-refilled word, so a refill that skipped or reordered banks would return wrong data. It also writes to uncached blocks and then reads them, which exposes a design that allocates on writes, and it checks that a reset in mid-run invalidates lines that were filled before it.

// File: rtl/cachePkg.sv
package cachePkg;
  localparam int BANKS  = 4;
  localparam int BANK_W = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_WRITE} stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic              fillWe;    // a refill word is on the bus this cycle
    logic [BANK_W-1:0] fillWord;  // which word/bank is being transferred
    logic              fillDone;  // last refill cycle: mark line valid
    logic              wrCommit;  // memory takes the write word this cycle
  } strobeT;
endpackage

// File: rtl/cacheCtrl.sv
module cacheCtrl
  import cachePkg::*;
#(
  parameter int ADDR_SEND   = 1,
  parameter int BANK_ACCESS = 15
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   cpuReq,
  input  logic   cpuWe,
  input  logic   lineHit,
  output logic   cpuReady,
  output strobeT strb
);
  localparam int XFER_START   = ADDR_SEND + BANK_ACCESS;
  localparam int FILL_CYCLES  = XFER_START + BANKS;
  localparam int WRITE_CYCLES = ADDR_SEND + BANK_ACCESS;
  localparam int CNT_W        = $clog2(FILL_CYCLES + 1);

  stateT state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] xferOff;
  logic fillLast, writeLast;

  assign fillLast  = (state == ST_FILL)  && (cnt == CNT_W'(FILL_CYCLES - 1));
  assign writeLast = (state == ST_WRITE) && (cnt == CNT_W'(WRITE_CYCLES - 1));
  assign xferOff   = cnt - CNT_W'(XFER_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (cpuReq && cpuWe)                state <= ST_WRITE;
          else if (cpuReq && !cpuWe && !lineHit) state <= ST_FILL;
        end
        ST_FILL: begin
          cnt <= cnt + 1'b1;
          if (fillLast) state <= ST_IDLE;
        end
        ST_WRITE: begin
          cnt <= cnt + 1'b1;
          if (writeLast) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.fillWe   = (state == ST_FILL) && (cnt >= CNT_W'(XFER_START));
    strb.fillWord = xferOff[BANK_W-1:0];
    strb.fillDone = fillLast;
    strb.wrCommit = writeLast;
    cpuReady      = ((state == ST_IDLE) && cpuReq && !cpuWe && lineHit) || writeLast;
  end

  // R4: processor is held off for the whole refill
  a_r4_stall_in_fill: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL) |-> !cpuReady);

  // R7: a write is never answered in the cycle it is presented
  a_r7_write_stalls: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && cpuReq && cpuWe) |-> !cpuReady);

  // R9: no completion without a request
  a_r9_ready_needs_req: assert property (@(posedge clk) disable iff (rst)
    cpuReady |-> cpuReq);
endmodule

// File: rtl/cacheDatapath.sv
module cacheDatapath
  import cachePkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LINES     = 256,
  parameter int MEM_WORDS = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  strobeT            strb,
  output logic              lineHit,
  output logic [DATA_W-1:0] cpuRdata
);
  localparam int BYTE_W    = 2;
  localparam int OFF_W     = BYTE_W + BANK_W;
  localparam int IDX_W     = $clog2(LINES);
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W;
  localparam int BANK_ROWS = MEM_WORDS / BANKS;
  localparam int ROW_W     = $clog2(BANK_ROWS);

  logic [TAG_W-1:0]  addrTag;
  logic [IDX_W-1:0]  addrIdx;
  logic [BANK_W-1:0] wordSel;
  logic [ROW_W-1:0]  bankRow;
  logic              unusedByteBits;

  assign addrTag        = cpuAddr[ADDR_W-1 -: TAG_W];
  assign addrIdx        = cpuAddr[OFF_W +: IDX_W];
  assign wordSel        = cpuAddr[BYTE_W +: BANK_W];
  assign bankRow        = cpuAddr[OFF_W +: ROW_W];
  assign unusedByteBits = ^cpuAddr[BYTE_W-1:0];

  logic [LINES-1:0]  validVec;
  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [DATA_W-1:0] dataMem [LINES][BANKS];
  logic [DATA_W-1:0] bankRd  [BANKS];

  assign lineHit  = validVec[addrIdx] && (tagMem[addrIdx] == addrTag);
  assign cpuRdata = dataMem[addrIdx][wordSel];

  // interleaved main memory: word bits select the bank
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] bankMem [BANK_ROWS];
    assign bankRd[b] = bankMem[bankRow];
    always_ff @(posedge clk) begin
      if (strb.wrCommit && (wordSel == BANK_W'(b)))
        bankMem[bankRow] <= cpuWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validVec <= '0;
    end else if (strb.fillDone) begin
      validVec[addrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fillDone) tagMem[addrIdx] <= addrTag;
    if (strb.fillWe)
      dataMem[addrIdx][strb.fillWord] <= bankRd[strb.fillWord];
    else if (strb.wrCommit && lineHit)
      dataMem[addrIdx][wordSel] <= cpuWdata;
  end

  // R4: after the last refill cycle the held request hits
  a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (rst)
    strb.fillDone |=> lineHit);

  // R7: a write leaves every valid flag unchanged
  a_r7_write_keeps_valid: assert property (@(posedge clk) disable iff (rst)
    strb.wrCommit |=> (validVec == $past(validVec)));

  // R8: the line is never written while a refill is on the bus
  a_r8_no_write_during_fill: assert property (@(posedge clk) disable iff (rst)
    strb.fillWe |-> !strb.wrCommit);
endmodule

// File: rtl/dmCache.sv
module dmCache
  import cachePkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINES       = 256,
  parameter int MEM_WORDS   = 2048,
  parameter int ADDR_SEND   = 1,
  parameter int BANK_ACCESS = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata
);
  strobeT strb;
  logic   lineHit;

  cacheCtrl #(
    .ADDR_SEND  (ADDR_SEND),
    .BANK_ACCESS(BANK_ACCESS)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cpuReq  (cpuReq),
    .cpuWe   (cpuWe),
    .lineHit (lineHit),
    .cpuReady(cpuReady),
    .strb    (strb)
  );

  cacheDatapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LINES    (LINES),
    .MEM_WORDS(MEM_WORDS)
  ) i_dp (
    .clk     (clk),
    .rst     (rst),
    .cpuAddr (cpuAddr),
    .cpuWdata(cpuWdata),
    .strb    (strb),
    .lineHit (lineHit),
    .cpuRdata(cpuRdata)
  );
endmodule

// File: tb/test_dmCache.sv
`timescale 1ns/1ps
module test_dmCache;
  localparam int LAT_HIT   = 0;
  localparam int LAT_MISS  = 21;
  localparam int LAT_WRITE = 16;
  localparam int NVEC      = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic cpuReady;
  logic [31:0] cpuRdata;

  int testCnt = 0, failCnt = 0;
  bit finished = 1'b0;
  logic [31:0] refMem [2048];

  always #2 clk = ~clk;

  dmCache i_dmCache (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRdata(cpuRdata)
  );

  // {we, address, write data, expected latency}
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b1, 32'h0000_0000, 32'h1111_1111, 8'd16},  // write miss
    {1'b1, 32'h0000_0004, 32'h2222_2222, 8'd16},
    {1'b1, 32'h0000_0008, 32'h3333_3333, 8'd16},
    {1'b1, 32'h0000_000C, 32'h4444_4444, 8'd16},
    {1'b1, 32'h0000_1000, 32'hAAAA_0000, 8'd16},  // same index, other tag
    {1'b1, 32'h0000_1004, 32'hAAAA_0004, 8'd16},
    {1'b1, 32'h0000_1008, 32'hAAAA_0008, 8'd16},
    {1'b1, 32'h0000_100C, 32'hAAAA_000C, 8'd16},
    {1'b0, 32'h0000_0000, 32'h0,         8'd21},  // no allocate: miss
    {1'b0, 32'h0000_0008, 32'h0,         8'd0},
    {1'b0, 32'h0000_0004, 32'h0,         8'd0},
    {1'b0, 32'h0000_1004, 32'h0,         8'd21},  // conflict
    {1'b0, 32'h0000_1000, 32'h0,         8'd0},
    {1'b0, 32'h0000_0000, 32'h0,         8'd21},  // evicted
    {1'b1, 32'h0000_0004, 32'h5555_5555, 8'd16},  // write hit
    {1'b0, 32'h0000_0004, 32'h0,         8'd0},
    {1'b1, 32'h0000_0050, 32'h0000_0066, 8'd16},
    {1'b0, 32'h0000_0050, 32'h0,         8'd21},
    {1'b0, 32'h0000_1004, 32'h0,         8'd21}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output int lat, output logic [31:0] rd);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    lat = 0;
    #1;
    while (!cpuReady && lat < 100) begin
      @(negedge clk); #1;
      lat++;
    end
    rd = cpuRdata;
    if (we) refMem[a[12:2]] = d;
    @(posedge clk); #1;
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic doCheck(input logic we, input logic [31:0] a, input logic [31:0] d,
                         input int expLat, input string req);
    int lat;
    logic [31:0] rd;
    access(we, a, d, lat, rd);
    check(lat == expLat, req, "latency", 32'(lat), 32'(expLat));
    if (!we) check(rd === refMem[a[12:2]], req, "read data", rd, refMem[a[12:2]]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check(cpuReady == 1'b0, "R9", "ready after reset", 32'(cpuReady), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic we;
      string req;
      we  = VEC[i][72];
      req = we ? "R7" : ((int'(VEC[i][7:0]) == LAT_HIT) ? "R3" : "R4");
      doCheck(we, VEC[i][71:40], VEC[i][39:8], int'(VEC[i][7:0]), req);
    end

    // R1: byte offset bits ignored
    doCheck(1'b0, 32'h0000_1006, 32'h0, LAT_HIT, "R1");
    // R5: other words of the refilled block hit
    doCheck(1'b0, 32'h0000_100C, 32'h0, LAT_HIT, "R5");
    doCheck(1'b0, 32'h0000_1000, 32'h0, LAT_HIT, "R5");
    // R6: conflict replaces the line, old block misses again
    doCheck(1'b0, 32'h0000_000C, 32'h0, LAT_MISS, "R6");
    doCheck(1'b0, 32'h0000_1008, 32'h0, LAT_MISS, "R6");
    // R8: write hit updates the cached word
    doCheck(1'b1, 32'h0000_1008, 32'hBEEF_0008, LAT_WRITE, "R8");
    doCheck(1'b0, 32'h0000_1008, 32'h0, LAT_HIT, "R8");
    // R7: write miss does not allocate
    doCheck(1'b1, 32'h0000_00C0, 32'h7777_7777, LAT_WRITE, "R7");
    doCheck(1'b0, 32'h0000_00C0, 32'h0, LAT_MISS, "R7");
    // R9: idle port never signals ready
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(cpuReady == 1'b0, "R9", "ready while idle", 32'(cpuReady), 32'd0);
    end
    // R2: mid-run reset invalidates filled lines
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    doCheck(1'b0, 32'h0000_1008, 32'h0, LAT_MISS, "R2");
    doCheck(1'b0, 32'h0000_00C4, 32'h0, LAT_MISS, "R2");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      testCnt++;
      failCnt++;
      $display("FAIL R4 watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule